// File: doc/BRIEF.md
# Access-Triggered Control Register Window

This block decodes a sixteen-location I/O register window. Several locations act on the bus strobes themselves instead of on the data: a write of any value to one of them sets a control level, and a read of the same location clears it. The levels driven this way are the watchdog enable, the count-clock rate select and the two isolated/LED output drives. A bit-mapped CONTROL register at the top of the window holds those same levels next to the enables for the reset sources, the fan restart bit and the global interrupt enable. A strobe and a CONTROL write therefore never disagree, and a read of CONTROL always shows the live state.

The block also merges the three reset sources into one system reset request. It turns a high-then-low sequence on the fan restart bit into a single-cycle pulse. The counter and interrupt logic sit outside this block and take the levels and pulses it drives.

Top module: `ctlwin_top`

## Requirements
- R1: After an active-low synchronous reset, all eight CONTROL bits are zero. The watchdog is disabled, both outputs are off, the high-rate clock is selected (slow_clk_sel low), interrupts are disabled and fan_restart is low.
- R2: A write of any data to offset 0xD sets out1_on from the next cycle on. A read of offset 0xD clears it.
- R3: A write of any data to offset 0xE sets out2_on from the next cycle on. A read of offset 0xE clears it.
- R4: A write to offset 0xC selects the low-rate clock (slow_clk_sel high) from the next cycle on. A read of 0xC selects the high rate. The selection holds while no other access touches it.
- R5: A write to offset 0x7 enables the watchdog (wdog_en high) from the next cycle on. A read of 0x7 disables it.
- R6: A write to offset 0xF loads CONTROL from the write data on the next cycle. The bit map is: bit 0 watchdog enable, bit 1 output 1, bit 2 output 2, bit 3 isolated-input-2 reset enable, bit 4 low-rate clock, bit 5 pushbutton reset enable, bit 6 fan restart, bit 7 interrupt enable. wdog_en, out1_on, out2_on, slow_clk_sel and irq_master_en follow bits 0, 1, 2, 4 and 7.
- R7: During a read of offset 0xF, bus_rdata shows CONTROL in the same cycle, including bits last changed by strobes. During any other cycle bus_rdata is zero.
- R8: sys_reset is high exactly when wdt_expired is high, or pbutton_n is low with CONTROL bit 5 set, or iso2_active is high with CONTROL bit 3 set. This path is combinational.
- R9: fan_restart pulses high for one cycle in the cycle after CONTROL bit 6 changes from 1 to 0. It stays low on a 0-to-1 change and while the bit is steady.
- R10: When bus_rd and bus_wr are both high in the same cycle, the write is performed and the read has no effect.
- R11: Reads and writes to offsets 0x0 to 0x6 and 0x8 to 0xB leave CONTROL and all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register offset within the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | CONTROL value during a read of 0xF, else zero |
| wdt_expired | input | 1 | Watchdog timeout from the counter chain |
| pbutton_n | input | 1 | Reset pushbutton, active low |
| iso2_active | input | 1 | Isolated input 2 is driven |
| wdog_en | output | 1 | Counters may run |
| out1_on | output | 1 | Isolated output 1 and LED 1 sink on |
| out2_on | output | 1 | Isolated output 2 and LED 2 sink on |
| slow_clk_sel | output | 1 | 1 selects the low-rate count clock |
| irq_master_en | output | 1 | Global interrupt enable |
| sys_reset | output | 1 | Merged reset request, active high |
| fan_restart | output | 1 | One-cycle fan restart pulse |

## Verification
A read strobe and a write strobe can land in the same cycle on a level-setting location. The bench drives both high together on offsets 0xD and 0x7 while the level is off, and expects the level to come on (R10). It does the same at 0xF, where the write must load CONTROL and bus_rdata must stay zero. A second overlap is a CONTROL write that moves bit 6 from 1 to 0 in the same cycle as it changes the other bits. The reference model expects the fan pulse and the new levels on the same following cycle.

// File: rtl/ctlwin_pkg.sv
// Package: shared bit positions and strobe indices for the control window.
// Assumes an 8-bit CONTROL register. Bit positions are fixed because
// outside logic decodes them.
package ctlwin_pkg;
    localparam int CTRL_W   = 8;
    // CONTROL bit positions
    localparam int B_WDOG   = 0;
    localparam int B_OUT1   = 1;
    localparam int B_OUT2   = 2;
    localparam int B_ISO2EN = 3;
    localparam int B_SLOW   = 4;
    localparam int B_PBEN   = 5;
    localparam int B_FAN    = 6;
    localparam int B_IRQ    = 7;
    // indices of the decoded strobe locations
    localparam int A_CTRL   = 0;
    localparam int A_WDOG   = 1;
    localparam int A_RATE   = 2;
    localparam int A_OUT1   = 3;
    localparam int A_OUT2   = 4;
    localparam int NACT     = 5;
endpackage

// File: rtl/ctlwin_decode.sv
// Module: decodes the bus strobes into per-location read and write hits.
// Assumes at most one access per cycle. If both strobes are high, the
// write wins and the read is suppressed.
module ctlwin_decode #(
    parameter int                      ADDR_W   = 4,
    parameter int                      NLOC     = 5,
    parameter logic [NLOC*ADDR_W-1:0]  OFS_LIST = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [NLOC-1:0]   rd_hit,
    output logic [NLOC-1:0]   wr_hit
);
    logic rd_ok;

    // write has priority over a simultaneous read
    assign rd_ok = bus_rd & ~bus_wr;

    for (genvar i = 0; i < NLOC; i++) begin : g_loc
        localparam logic [ADDR_W-1:0] OFS = OFS_LIST[i*ADDR_W +: ADDR_W];
        // one comparator per decoded location
        assign rd_hit[i] = rd_ok  && (bus_addr == OFS);
        assign wr_hit[i] = bus_wr && (bus_addr == OFS);
    end
endmodule

// File: rtl/ctlwin_state.sv
// Module: holds the CONTROL register. Strobe side effects and CONTROL
// writes update the same flops, so there is one copy of every level.
// Also detects the 1-to-0 edge of the fan bit.
// Assumes at most one hit per cycle, as the decoder guarantees.
module ctlwin_state
    import ctlwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NACT-1:0]   rd_hit,
    input  logic [NACT-1:0]   wr_hit,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              fan_pulse
);
    logic [CTRL_W-1:0] ctrl_d;

    // next CONTROL value from whichever access hit this cycle
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_hit[A_CTRL]) ctrl_d = wr_data;
        if (wr_hit[A_WDOG]) ctrl_d[B_WDOG] = 1'b1;
        if (rd_hit[A_WDOG]) ctrl_d[B_WDOG] = 1'b0;
        if (wr_hit[A_RATE]) ctrl_d[B_SLOW] = 1'b1;
        if (rd_hit[A_RATE]) ctrl_d[B_SLOW] = 1'b0;
        if (wr_hit[A_OUT1]) ctrl_d[B_OUT1] = 1'b1;
        if (rd_hit[A_OUT1]) ctrl_d[B_OUT1] = 1'b0;
        if (wr_hit[A_OUT2]) ctrl_d[B_OUT2] = 1'b1;
        if (rd_hit[A_OUT2]) ctrl_d[B_OUT2] = 1'b0;
    end

    // register CONTROL and the fan falling-edge pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            fan_pulse <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_d;
            fan_pulse <= ctrl_q[B_FAN] & ~ctrl_d[B_FAN];
        end
    end
endmodule

// File: rtl/ctlwin_rstmux.sv
// Module: merges the three reset sources into one request.
// Assumes the pushbutton is active low and the isolated input active high.
module ctlwin_rstmux (
    input  logic wdt_expired,
    input  logic pbutton_n,
    input  logic pb_en,
    input  logic iso2_active,
    input  logic iso2_en,
    output logic sys_reset
);
    // OR of the timeout and the two gated external sources
    assign sys_reset = wdt_expired | (~pbutton_n & pb_en) | (iso2_active & iso2_en);
endmodule

// File: rtl/ctlwin_top.sv
// Module: top of the access-triggered control window. Wires the decoder,
// the CONTROL state and the reset merge, and drives the read path for
// CONTROL. Assumes single-cycle bus strobes.
module ctlwin_top
    import ctlwin_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int OFS_CTRL = 15,
    parameter int OFS_WDOG = 7,
    parameter int OFS_RATE = 12,
    parameter int OFS_OUT1 = 13,
    parameter int OFS_OUT2 = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [CTRL_W-1:0] bus_rdata,
    input  logic              wdt_expired,
    input  logic              pbutton_n,
    input  logic              iso2_active,
    output logic              wdog_en,
    output logic              out1_on,
    output logic              out2_on,
    output logic              slow_clk_sel,
    output logic              irq_master_en,
    output logic              sys_reset,
    output logic              fan_restart
);
    localparam logic [NACT*ADDR_W-1:0] OFS_LIST = {
        ADDR_W'(OFS_OUT2), ADDR_W'(OFS_OUT1), ADDR_W'(OFS_RATE),
        ADDR_W'(OFS_WDOG), ADDR_W'(OFS_CTRL)};

    logic [NACT-1:0]   rd_hit;
    logic [NACT-1:0]   wr_hit;
    logic [CTRL_W-1:0] ctrl_q;

    ctlwin_decode #(
        .ADDR_W   (ADDR_W),
        .NLOC     (NACT),
        .OFS_LIST (OFS_LIST)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit)
    );

    ctlwin_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_hit    (rd_hit),
        .wr_hit    (wr_hit),
        .wr_data   (bus_wdata),
        .ctrl_q    (ctrl_q),
        .fan_pulse (fan_restart)
    );

    ctlwin_rstmux u_rstmux (
        .wdt_expired (wdt_expired),
        .pbutton_n   (pbutton_n),
        .pb_en       (ctrl_q[B_PBEN]),
        .iso2_active (iso2_active),
        .iso2_en     (ctrl_q[B_ISO2EN]),
        .sys_reset   (sys_reset)
    );

    // CONTROL read path, zero outside a read of its location
    assign bus_rdata     = rd_hit[A_CTRL] ? ctrl_q : '0;
    assign wdog_en       = ctrl_q[B_WDOG];
    assign out1_on       = ctrl_q[B_OUT1];
    assign out2_on       = ctrl_q[B_OUT2];
    assign slow_clk_sel  = ctrl_q[B_SLOW];
    assign irq_master_en = ctrl_q[B_IRQ];
endmodule

// File: rtl/ctlwin_chk.sv
// Module: assertion checker for ctlwin_top, attached by bind.
// Assumes the default offsets of the top module.
module ctlwin_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic [7:0] ctrl_q,
    input logic       wdt_expired,
    input logic       out1_on,
    input logic       out2_on,
    input logic       wdog_en,
    input logic       slow_clk_sel,
    input logic       sys_reset,
    input logic       fan_restart
);
    logic rd_only;
    logic other_ofs;
    assign rd_only   = bus_rd && !bus_wr;
    assign other_ofs = (bus_addr < 4'h7) || ((bus_addr > 4'h7) && (bus_addr < 4'hC));

    p_out1_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'hD) |=> out1_on);
    p_out1_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && bus_addr == 4'hD) |=> !out1_on);
    p_out2_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'hE) |=> out2_on);
    p_rate_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && bus_addr == 4'hC) |=> !slow_clk_sel);
    p_wdog_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h7) |=> wdog_en);
    p_rdata_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata != 8'h00) |-> (rd_only && bus_addr == 4'hF));
    p_wdt_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expired |-> sys_reset);
    p_fan_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fan_restart |-> (!ctrl_q[6] && $past(ctrl_q[6])));
    p_fan_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fan_restart |=> !fan_restart);
    p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr && bus_addr == 4'hD) |=> out1_on);
    p_other_ofs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && other_ofs) |=> $stable(ctrl_q));
endmodule

bind ctlwin_top ctlwin_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .ctrl_q       (ctrl_q),
    .wdt_expired  (wdt_expired),
    .out1_on      (out1_on),
    .out2_on      (out2_on),
    .wdog_en      (wdog_en),
    .slow_clk_sel (slow_clk_sel),
    .sys_reset    (sys_reset),
    .fan_restart  (fan_restart)
);

// File: tb/ctlwin_top_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of CONTROL, compared on every clock.
module ctlwin_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wdt_expired = 1'b0;
    logic       pbutton_n = 1'b1;
    logic       iso2_active = 1'b0;
    logic       wdog_en, out1_on, out2_on, slow_clk_sel, irq_master_en;
    logic       sys_reset, fan_restart;

    int vectors = 0;
    int miscompares = 0;
    int model = 0;
    int exp_fan = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    ctlwin_top u_ctlwin_top (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_rd (bus_rd),
        .bus_wr (bus_wr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .wdt_expired (wdt_expired), .pbutton_n (pbutton_n),
        .iso2_active (iso2_active), .wdog_en (wdog_en), .out1_on (out1_on),
        .out2_on (out2_on), .slow_clk_sel (slow_clk_sel),
        .irq_master_en (irq_master_en), .sys_reset (sys_reset),
        .fan_restart (fan_restart)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // registered outputs against the model
    task automatic check_regs(input string tag);
        chk(tag, "wdog_en", int'(wdog_en), (model >> 0) & 1);
        chk(tag, "out1_on", int'(out1_on), (model >> 1) & 1);
        chk(tag, "out2_on", int'(out2_on), (model >> 2) & 1);
        chk(tag, "slow_clk_sel", int'(slow_clk_sel), (model >> 4) & 1);
        chk(tag, "irq_master_en", int'(irq_master_en), (model >> 7) & 1);
        chk(tag, "fan_restart", int'(fan_restart), exp_fan);
    endtask

    // one bus cycle: check, drive, check combinational paths, advance model
    task automatic step(input string tag, input bit rd, input bit wr,
                        input int a, input int d);
        int nm;
        int exp_rd;
        int exp_rst;
        @(negedge clk);
        check_regs(cur_tag);
        cur_tag = tag;
        bus_rd = rd; bus_wr = wr; bus_addr = 4'(a); bus_wdata = 8'(d);
        #1;
        exp_rd = (rd && !wr && a == 15) ? model : 0;
        chk(tag, "bus_rdata", int'(bus_rdata), exp_rd);
        exp_rst = (wdt_expired || (!pbutton_n && ((model >> 5) & 1) == 1) ||
                   (iso2_active && ((model >> 3) & 1) == 1)) ? 1 : 0;
        chk(tag, "sys_reset", int'(sys_reset), exp_rst);
        nm = model;
        if (wr) begin
            case (a)
                15: nm = d & 8'hFF;
                7:  nm = nm | 8'h01;
                12: nm = nm | 8'h10;
                13: nm = nm | 8'h02;
                14: nm = nm | 8'h04;
                default: ;
            endcase
        end else if (rd) begin
            case (a)
                7:  nm = nm & 8'hFE;
                12: nm = nm & 8'hEF;
                13: nm = nm & 8'hFD;
                14: nm = nm & 8'hFB;
                default: ;
            endcase
        end
        exp_fan = (((model >> 6) & 1) == 1 && ((nm >> 6) & 1) == 0) ? 1 : 0;
        model = nm;
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, 0, 0);
    endtask

    initial begin
        #(200000 * 20);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_regs("R1");
        chk("R1", "bus_rdata", int'(bus_rdata), 0);
        chk("R1", "sys_reset", int'(sys_reset), 0);
        rst_n = 1'b1;
        idle("R1");
        // R2: output 1 strobes, data ignored
        step("R2", 0, 1, 13, 8'h00);
        idle("R2");
        step("R2", 1, 0, 13, 8'hFF);
        step("R2", 0, 1, 13, 8'h5A);
        step("R7", 1, 0, 15, 0);
        step("R2", 1, 0, 13, 0);
        // R3: output 2 strobes
        step("R3", 0, 1, 14, 8'hA5);
        step("R7", 1, 0, 15, 0);
        step("R3", 1, 0, 14, 0);
        // R4: clock rate select holds
        step("R4", 0, 1, 12, 8'h00);
        idle("R4");
        idle("R4");
        step("R7", 1, 0, 15, 0);
        step("R4", 1, 0, 12, 0);
        idle("R4");
        // R5: watchdog enable strobes
        step("R5", 0, 1, 7, 8'h33);
        step("R7", 1, 0, 15, 0);
        step("R5", 1, 0, 7, 0);
        // R6: CONTROL loads
        step("R6", 0, 1, 15, 8'hFF);
        step("R7", 1, 0, 15, 0);
        step("R6", 0, 1, 15, 8'h96);
        step("R7", 1, 0, 15, 0);
        step("R6", 0, 1, 15, 8'h00);
        // R9: fan bit edges, combined with other bits changing
        step("R9", 0, 1, 15, 8'h40);
        step("R9", 0, 1, 15, 8'h40);
        step("R9", 0, 1, 15, 8'h95);
        idle("R9");
        step("R9", 0, 1, 15, 8'h00);
        idle("R9");
        // R8: reset sources, with enables off then on
        wdt_expired = 1'b1;
        idle("R8");
        wdt_expired = 1'b0;
        pbutton_n = 1'b0;
        iso2_active = 1'b1;
        idle("R8");
        step("R8", 0, 1, 15, 8'h20);
        idle("R8");
        pbutton_n = 1'b1;
        idle("R8");
        step("R8", 0, 1, 15, 8'h08);
        idle("R8");
        iso2_active = 1'b0;
        idle("R8");
        step("R8", 0, 1, 15, 8'h00);
        // R10: read and write in the same cycle
        step("R10", 1, 1, 13, 0);
        step("R10", 1, 1, 7, 0);
        step("R10", 1, 1, 15, 8'hC3);
        step("R7", 1, 0, 15, 0);
        step("R10", 1, 1, 12, 0);
        // R11: other offsets leave everything unchanged
        for (int a = 0; a < 12; a++) begin
            if (a != 7) begin
                step("R11", 0, 1, a, 8'hFF);
                step("R11", 1, 0, a, 0);
            end
        end
        step("R7", 1, 0, 15, 0);
        idle("R11");
        idle("R11");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule